// File: doc/BRIEF.md
# Serial-Loaded Octal Register Bank

This block is the digital front end of an eight-channel trim converter. A slow three-wire serial port delivers 11-bit frames. Each frame carries a 3-bit channel number in its upper bits and an 8-bit code in its lower bits. The three port lines are a low-active select, a serial clock and a data line. All of them are sampled in the system clock domain: a two-flop synchroniser feeds an edge detector, so the serial clock is oversampled and is never used as a clock.

While select is low, every rising serial-clock edge shifts one data bit into an 11-bit frame register, most significant bit first. Only the most recent 11 bits are kept. When select returns high, the frame is decoded and exactly one of eight channel registers takes the code. Writing every channel therefore takes eight frames.

A synchronous reset puts every channel at midscale (128). A low-active shutdown input clears the per-channel drive-enable flags, marking the outputs as open. The stored codes stay as they are, so the outputs come back with their old values when shutdown is released.

Top module: `sdac_ctrl`

## Requirements
- R1: While `rst` is high, every 8-bit field of `codes` becomes 128 (0x80) and `drive_en` becomes all zeros; the fields stay at 128 after reset until a frame loads them.
- R2: A frame is sent most significant bit first. Bits 10..8 are the channel number n, and bits 7..0 are the code. The code goes into `codes[8n+7:8n]`.
- R3: A completed frame changes only the addressed channel; the other seven fields keep their values, and no more than one field changes in any clock cycle.
- R4: When more than 11 bits are clocked in during one select period, only the last 11 bits decide the channel and the code.
- R5: Serial-clock edges while `sel_n` is high do not shift the frame register. A later select period with no clock edges reloads the frame that was last completed.
- R6: No channel changes while `sel_n` stays low. The load happens only after the low-to-high transition of `sel_n`, a few system clocks later.
- R7: While `sleep_n` is low, `drive_en` is all zeros and the stored codes are unchanged. One clock after `sleep_n` returns high, `drive_en` is all ones again and `codes` still shows the values held before shutdown.
- R8: A frame completed during shutdown still updates its channel, and `drive_en` stays all zeros.
- R9: Eight frames with eight different channel numbers, in any order, set all eight channels to their own codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial port |
| rst | input | 1 | Synchronous active-high reset to midscale |
| sel_n | input | 1 | Serial select, low while a frame is being sent; the load happens on its rising edge |
| sclk | input | 1 | Serial clock; a bit is shifted on each rising edge while selected |
| sdata | input | 1 | Serial data, most significant bit first |
| sleep_n | input | 1 | Low-active shutdown; clears all drive-enable flags |
| codes | output | 64 | Eight 8-bit channel codes; channel n sits at bits 8n+7..8n |
| drive_en | output | 8 | Per-channel output-enable flags, one bit per channel |

## Verification
The register load and shutdown are independent, so a frame can complete while shutdown is held. The bench forces this case by asserting `sleep_n` low, sending a full frame, and raising select while still in shutdown. It then checks that the addressed field holds the new code, that `drive_en` stays all zeros throughout, and that the flags return while the new code is kept. Reset is also applied on top of channels that already hold loaded values, and every field must come back at midscale.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DEF_CH      = 8;
  localparam int DEF_CW      = 8;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W      = 3,
  parameter int STAGES = sdac_pkg::SYNC_STAGES,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= INIT;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int AW = 3,
  parameter int CW = 8,
  localparam int FW = AW + CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n_s,
  input  logic          sclk_s,
  input  logic          sdata_s,
  output logic          load,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] code
);
  logic          sel_q;
  logic          sclk_q;
  logic [FW-1:0] frame_q;
  logic          shift_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_n_s;
      sclk_q <= sclk_s;
    end
  end

  assign shift_en = sclk_s & ~sclk_q & ~sel_n_s;
  assign load     = sel_n_s & ~sel_q;

  always_ff @(posedge clk) begin
    if (rst)           frame_q <= '0;
    else if (shift_en) frame_q <= {frame_q[FW-2:0], sdata_s};
  end

  assign addr = frame_q[FW-1:CW];
  assign code = frame_q[CW-1:0];
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank #(
  parameter int CH = 8,
  parameter int CW = 8,
  localparam int AW = $clog2(CH),
  localparam logic [CW-1:0] MID = CW'(1) << (CW - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    code,
  output logic [CH*CW-1:0] codes
);
  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [CW-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)                             val_q <= MID;
      else if (load && addr == AW'(g))     val_q <= code;
    end
    assign codes[g*CW +: CW] = val_q;
  end
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl #(
  parameter int CH = sdac_pkg::DEF_CH,
  parameter int CW = sdac_pkg::DEF_CW,
  localparam int AW = $clog2(CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             sleep_n,
  output logic [CH*CW-1:0] codes,
  output logic [CH-1:0]    drive_en
);
  logic          sel_n_s, sclk_s, sdata_s;
  logic          load;
  logic [AW-1:0] addr;
  logic [CW-1:0] code;

  sdac_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sel_n, sclk, sdata}),
    .q   ({sel_n_s, sclk_s, sdata_s})
  );

  sdac_frame #(.AW(AW), .CW(CW)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .sel_n_s (sel_n_s),
    .sclk_s  (sclk_s),
    .sdata_s (sdata_s),
    .load    (load),
    .addr    (addr),
    .code    (code)
  );

  sdac_bank #(.CH(CH), .CW(CW)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .addr  (addr),
    .code  (code),
    .codes (codes)
  );

  always_ff @(posedge clk) begin
    if (rst) drive_en <= '0;
    else     drive_en <= {CH{sleep_n}};
  end
endmodule

// File: rtl/sdac_ctrl_chk.sv
module sdac_ctrl_chk #(
  parameter int CH = 8,
  parameter int CW = 8,
  localparam logic [CW-1:0] MID = CW'(1) << (CW - 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic             sleep_n,
  input logic [CH*CW-1:0] codes,
  input logic [CH-1:0]    drive_en
);
  logic [CH*CW-1:0] prev_codes;
  logic [CH-1:0]    chg;

  always_ff @(posedge clk) prev_codes <= codes;

  for (genvar g = 0; g < CH; g++) begin : g_cmp
    assign chg[g] = codes[g*CW +: CW] != prev_codes[g*CW +: CW];
  end

  AST_RESET_MID: assert property (@(posedge clk)
    rst |=> (codes == {CH{MID}} && drive_en == '0));                   // R1

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);                                              // R3

  AST_HOLD_WHILE_SEL: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !$past(sel_n) && !$past(sel_n, 2) && !$past(sel_n, 3))
      |-> $stable(codes));                                              // R6

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    !sleep_n |=> drive_en == '0);                                       // R7

  AST_WAKE_ON: assert property (@(posedge clk) disable iff (rst)
    sleep_n |=> drive_en == '1);                                        // R7
endmodule

bind sdac_ctrl sdac_ctrl_chk #(.CH(CH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_n    (sel_n),
  .sleep_n  (sleep_n),
  .codes    (codes),
  .drive_en (drive_en)
);

// File: tb/sdac_ctrl_bench.sv
module sdac_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 8;
  localparam int CW = 8;
  localparam int HALF = 4;

  // frame table: {channel[2:0], code[7:0]} walked in order
  localparam logic [10:0] VEC [8] = '{
    {3'd5, 8'h3A}, {3'd0, 8'hFF}, {3'd7, 8'h00}, {3'd2, 8'h81},
    {3'd4, 8'h5C}, {3'd1, 8'h01}, {3'd6, 8'hC3}, {3'd3, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, sclk = 1'b0, sdata = 1'b0, sleep_n = 1'b1;
  logic [CH*CW-1:0] codes;
  logic [CH-1:0]    drive_en;
  logic [CW-1:0]    model [CH];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_ctrl #(.CH(CH), .CW(CW)) u_sdac_ctrl (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .sleep_n(sleep_n), .codes(codes), .drive_en(drive_en)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    sel_n = 1'b0;
    wait_clk(HALF);
    shift_bits(v, n);
    sel_n = 1'b1;
    wait_clk(8);
    if (n >= 11) model[v[10:8]] = v[7:0];
  endtask

  task automatic check_codes(input string req);
    logic [CH*CW-1:0] e;
    for (int i = 0; i < CH; i++) e[i*CW +: CW] = model[i];
    checks++;
    if (codes !== e) begin
      errors++;
      $display("FAIL %s codes=%h expected=%h", req, codes, e);
    end
  endtask

  task automatic check_en(input string req, input logic [CH-1:0] e);
    checks++;
    if (drive_en !== e) begin
      errors++;
      $display("FAIL %s drive_en=%b expected=%b", req, drive_en, e);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < CH; i++) model[i] = 8'h80;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    wait_clk(4);
    check_codes("R1 reset midscale");
    check_en("R1 reset enables", '0);
    rst = 1'b0;
    wait_clk(3);
    check_en("R7 awake enables", '1);

    // R9, R2, R3: table walk, every field checked after each frame
    for (int k = 0; k < 8; k++) begin
      send({5'd0, VEC[k]}, 11);
      check_codes("R2 R3 R9 table frame");
    end

    // R4: three leading junk bits then a full frame
    send({2'b00, 3'b101, 3'd6, 8'h3C}, 14);
    check_codes("R4 last eleven bits kept");

    // R6: no load before select rises
    sel_n = 1'b0;
    wait_clk(HALF);
    shift_bits({5'd0, 3'd1, 8'hAA}, 11);
    wait_clk(10);
    check_codes("R6 held while selected");
    sel_n = 1'b1;
    wait_clk(8);
    model[1] = 8'hAA;
    check_codes("R6 load after select rise");

    // R5: clocks while deselected are ignored; empty frame reloads channel 1
    shift_bits({5'd0, 3'd5, 8'h11}, 11);
    model[5] = 8'h3A;
    model[1] = 8'h55;
    send({5'd0, 3'd1, 8'h55}, 11);
    shift_bits({5'd0, 3'd5, 8'h11}, 11);
    sel_n = 1'b0;
    wait_clk(HALF);
    sel_n = 1'b1;
    wait_clk(8);
    check_codes("R5 deselected clocks ignored");

    // R7, R8: shutdown keeps codes, load during shutdown still lands
    sleep_n = 1'b0;
    wait_clk(2);
    check_en("R7 shutdown clears enables", '0);
    check_codes("R7 codes kept in shutdown");
    send({5'd0, 3'd3, 8'h5A}, 11);
    check_codes("R8 load during shutdown");
    check_en("R8 enables stay off", '0);
    sleep_n = 1'b1;
    wait_clk(2);
    check_en("R7 enables back", '1);
    check_codes("R7 codes after wake");

    // R1: reset over loaded channels
    rst = 1'b1;
    wait_clk(3);
    model_reset();
    check_codes("R1 reset over loaded values");
    rst = 1'b0;
    wait_clk(3);
    check_codes("R1 midscale after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule